// File: doc/BRIEF.md
# Chained Event Counter Bank

A bank of programmable event counters plus one dedicated free-running cycle counter at index 31. Each event counter holds an event-type value and steps by one in any clock where its selected event is signalled, the bank is globally enabled and that counter's own enable bit is set. Two event codes are reserved and never come from the hardware event bus:

- Code 0x0000 marks a counter that steps on a software-increment write.
- Code 0x001E marks a counter that steps when its even-indexed neighbour overflows.

The chain between an even counter and the odd counter above it forms wider counts out of two 32-bit halves. The chained count lands in the same clock as the overflow that causes it.

Overflow is detected on a wrap of the low 32 bits to zero. The exception is a counter whose long-overflow control is set: event counters use one shared control, the cycle counter has its own, and a counter under long-overflow detects overflow on a full 64-bit wrap. Each overflow sets a sticky bit in the overflow-status output. A register port writes and reads counters and type registers. A read returns, one clock later, the value the register held at the requesting edge.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, every counter, every type register, `ovf_status` and `reg_rdata` are zero. In each clock, `reg_rdata` is loaded with the value, as it stood before that edge, of the register selected by `reg_idx` (`reg_sel`=0 selects a counter, `reg_sel`=1 selects a type register). Unimplemented indices, and the type of index 31, read zero and ignore writes.
- R2: An event counter steps only when all of the following hold:
  - `glb_en` is high.
  - Its `cnt_en` bit is high.
  - `evt_valid` is high.
  - Its stored type equals the low EW bits of `evt_code` (EW is 16 with the extended-counter option, 10 without).

  Type writes keep only the low EW bits of `reg_wdata`. Counters typed 0x0000 or 0x001E ignore the hardware event bus.
- R3: With the extended-counter option an event counter holds 64 bits. Without it, an event counter holds 32 bits.
- R4: An event counter that steps sets bit i of `ovf_status` when its new value is zero in the low 32 bits (`long_evt_ovf`=0) or in all 64 bits (`long_evt_ovf`=1). Status bits only clear on reset.
- R5: The 64-bit cycle counter at index 31 steps in every clock where `glb_en` and `cnt_en[31]` are high. It sets bit 31 on a wrap of its low 32 bits to zero, or on a 64-bit wrap when `long_cyc_ovf`=1.
- R6: When an even counter i with i+1 < NUM_EVT overflows with `long_evt_ovf`=0, counter i+1 counts one chain event in the same clock. Counter i+1 takes this event only if its type is 0x001E and it is enabled.
- R7: With `long_evt_ovf`=1, no overflow produces a chain event.
- R8: A clock with `sw_we` high steps every enabled event counter i where `sw_mask[i]` is set and the type is 0x0000. Overflow and chaining apply to these steps.
- R9: While `acc32_mode` is high, a counter write to an event counter keeps its upper 32 bits and replaces the lower 32. The cycle counter is always written in full.
- R10: A counter write in the same clock as a step of that counter wins: the written value is stored and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global counting enable |
| long_evt_ovf | input | 1 | Event counters overflow on 64-bit wrap (only with the extended option) |
| long_cyc_ovf | input | 1 | Cycle counter overflows on 64-bit wrap |
| acc32_mode | input | 1 | 32-bit access mode for event counter writes |
| cnt_en | input | 32 | Per-counter enable, bit 31 for the cycle counter |
| evt_valid | input | 1 | An event is signalled this clock |
| evt_code | input | 16 | Number of the signalled event |
| sw_we | input | 1 | Software-increment write strobe |
| sw_mask | input | 31 | Counters targeted by the software increment |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects a counter, 1 selects a type register |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| ovf_status | output | 32 | Sticky overflow bits |

## Verification
The hardest situation to reach is a chain step that coincides with an overflow. It needs an even counter sitting one step below a 32-bit wrap, a neighbour typed for chain events, and the long-overflow control in the right state, all at once. The stimulus preloads counters through the write port to values just below 2^32 and 2^64. It then fires single events or software increments and toggles the long-overflow control between attempts. A randomized phase also draws write values from a small set of near-wrap constants, so that chained overflows, write collisions and 32-bit access writes recur, and each clock is compared against a behavioural model.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned CYC_IDX  = 31;
  localparam logic [15:0] EV_SWINC = 16'h0000;
  localparam logic [15:0] EV_CHAIN = 16'h001E;

  function automatic int unsigned evt_width(input bit ext);
    return ext ? 16 : 10;
  endfunction
endpackage

// File: rtl/ecb_evt_ctr.sv
module ecb_evt_ctr #(
  parameter int unsigned CW = 64,
  parameter int unsigned EW = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        glb_en,
  input  logic        ctr_en,
  input  logic        long_ovf,
  input  logic        acc32,
  input  logic        evt_valid,
  input  logic [15:0] evt_code,
  input  logic        sw_hit,
  input  logic        chain_in,
  input  logic        cnt_we,
  input  logic        typ_we,
  input  logic [63:0] wdata,
  output logic [63:0] cnt_q,
  output logic [15:0] typ_q,
  output logic        ovf_pulse,
  output logic        chain_out
);
  import ecb_pkg::*;

  logic [CW-1:0] cnt;
  logic [EW-1:0] typ;
  logic [CW-1:0] nxt;
  logic [63:0]   cur64, wv64;
  logic          is_sw, is_ch, hit, wrap;

  assign is_sw = (typ == EV_SWINC[EW-1:0]);
  assign is_ch = (typ == EV_CHAIN[EW-1:0]);
  assign hit   = glb_en & ctr_en &
                 ((evt_valid & ~is_sw & ~is_ch & (evt_code[EW-1:0] == typ)) |
                  (sw_hit & is_sw) | (chain_in & is_ch));
  assign nxt   = cnt + 1'b1;
  assign wrap  = long_ovf ? (nxt == '0) : (nxt[31:0] == 32'd0);

  assign ovf_pulse = hit & ~cnt_we & wrap;
  assign chain_out = ovf_pulse & ~long_ovf;

  assign cur64 = 64'(cnt);
  assign wv64  = {acc32 ? cur64[63:32] : wdata[63:32], wdata[31:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      typ <= '0;
    end else begin
      if (cnt_we)   cnt <= wv64[CW-1:0];
      else if (hit) cnt <= nxt;
      if (typ_we)   typ <= wdata[EW-1:0];
    end
  end

  assign cnt_q = 64'(cnt);
  assign typ_q = 16'(typ);

  logic unused_bits;
  assign unused_bits = ^{evt_code, wv64, wdata};

  // R2: nothing moves while the bank is globally disabled
  p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !cnt_we) |=> $stable(cnt));

  // R3: without a write the counter moves by at most one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> ((cnt == $past(cnt)) || (cnt == CW'($past(cnt) + 1'b1))));

  generate
    if (CW == 64) begin : g_keep_hi
      // R9: 32-bit access writes keep the upper half
      p_keep_hi_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && acc32) |=> (cnt[CW-1:32] == $past(cnt[CW-1:32])));
    end
  endgenerate
endmodule

// File: rtl/ecb_cyc_ctr.sv
module ecb_cyc_ctr (
  input  logic        clk,
  input  logic        rst,
  input  logic        glb_en,
  input  logic        ctr_en,
  input  logic        long_ovf,
  input  logic        cnt_we,
  input  logic [63:0] wdata,
  output logic [63:0] cnt_q,
  output logic        ovf_pulse
);
  logic [63:0] cnt, nxt;
  logic        run;

  assign run = glb_en & ctr_en;
  assign nxt = cnt + 64'd1;
  assign ovf_pulse = run & ~cnt_we &
                     (long_ovf ? (nxt == 64'd0) : (nxt[31:0] == 32'd0));

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (cnt_we) cnt <= wdata;
    else if (run)    cnt <= nxt;
  end

  assign cnt_q = cnt;

  // R5: an enabled cycle counter steps every clock
  p_cyc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (glb_en && ctr_en && !cnt_we) |=> (cnt == $past(cnt) + 64'd1));

  // R9: the cycle counter is written in full
  p_cyc_write_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt == $past(wdata)));
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank #(
  parameter int unsigned NUM_EVT = 6,
  parameter bit          EXT_CNT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        glb_en,
  input  logic        long_evt_ovf,
  input  logic        long_cyc_ovf,
  input  logic        acc32_mode,
  input  logic [31:0] cnt_en,
  input  logic        evt_valid,
  input  logic [15:0] evt_code,
  input  logic        sw_we,
  input  logic [30:0] sw_mask,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [4:0]  reg_idx,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic [31:0] ovf_status
);
  import ecb_pkg::*;

  localparam int unsigned EW = evt_width(EXT_CNT);
  localparam int unsigned CW = EXT_CNT ? 64 : 32;

  logic        lp_eff;
  logic [63:0] cnt_q [NUM_EVT];
  logic [15:0] typ_q [NUM_EVT];
  logic [NUM_EVT-1:0] chain_out;
  logic [31:0] ovf_vec;
  logic [63:0] cyc_q;
  logic [63:0] rd_val;

  assign lp_eff = long_evt_ovf & EXT_CNT;

  genvar i;
  generate
    for (i = 0; i < NUM_EVT; i++) begin : g_ctr
      logic chain_in;
      if (i % 2 == 1) begin : g_odd
        assign chain_in = chain_out[i-1];
      end else begin : g_even
        assign chain_in = 1'b0;
      end
      ecb_evt_ctr #(.CW(CW), .EW(EW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .glb_en    (glb_en),
        .ctr_en    (cnt_en[i]),
        .long_ovf  (lp_eff),
        .acc32     (acc32_mode),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .sw_hit    (sw_we & sw_mask[i]),
        .chain_in  (chain_in),
        .cnt_we    (reg_we & ~reg_sel & (reg_idx == IDX_W'(i))),
        .typ_we    (reg_we &  reg_sel & (reg_idx == IDX_W'(i))),
        .wdata     (reg_wdata),
        .cnt_q     (cnt_q[i]),
        .typ_q     (typ_q[i]),
        .ovf_pulse (ovf_vec[i]),
        .chain_out (chain_out[i])
      );
    end
    for (i = NUM_EVT; i < CYC_IDX; i++) begin : g_absent
      assign ovf_vec[i] = 1'b0;
    end
  endgenerate

  ecb_cyc_ctr u_cyc (
    .clk       (clk),
    .rst       (rst),
    .glb_en    (glb_en),
    .ctr_en    (cnt_en[CYC_IDX]),
    .long_ovf  (long_cyc_ovf),
    .cnt_we    (reg_we & ~reg_sel & (reg_idx == IDX_W'(CYC_IDX))),
    .wdata     (reg_wdata),
    .cnt_q     (cyc_q),
    .ovf_pulse (ovf_vec[CYC_IDX])
  );

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (reg_idx == IDX_W'(k)) rd_val = reg_sel ? 64'(typ_q[k]) : cnt_q[k];
    end
    if (reg_idx == IDX_W'(CYC_IDX) && !reg_sel) rd_val = cyc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      ovf_status <= '0;
    end else begin
      reg_rdata  <= rd_val;
      ovf_status <= ovf_status | ovf_vec;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cnt_en, sw_mask};

  // R4: status bits are sticky
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_status & $past(ovf_status)) == $past(ovf_status)));

  // R7: long overflow mode never forwards a chain event
  p_no_chain_long_r7: assert property (@(posedge clk) disable iff (rst)
    lp_eff |-> (chain_out == '0));

  // R1: absent indices never report overflow
  p_absent_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_status[CYC_IDX-1:0] >> NUM_EVT) == '0));
endmodule

// File: tb/evt_ctr_bank_tb.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb;
  localparam int NE = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        glb_en = 0, long_evt = 0, long_cyc = 0, acc32 = 0;
  logic [31:0] cnt_en = '0;
  logic        evt_valid = 0;
  logic [15:0] evt_code = '0;
  logic        sw_we = 0;
  logic [30:0] sw_mask = '0;
  logic        reg_we = 0, reg_sel = 0;
  logic [4:0]  reg_idx = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [31:0] ovf_status;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_ctr_bank #(.NUM_EVT(NE), .EXT_CNT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .long_evt_ovf(long_evt),
    .long_cyc_ovf(long_cyc), .acc32_mode(acc32), .cnt_en(cnt_en),
    .evt_valid(evt_valid), .evt_code(evt_code), .sw_we(sw_we),
    .sw_mask(sw_mask), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ovf_status(ovf_status));

  // behavioural reference
  logic [63:0] m_cnt [32];
  logic [15:0] m_typ [32];
  logic [31:0] m_ovf;
  logic [63:0] m_rd;
  logic [63:0] rdv;
  bit chain_prev, nxt_chain, hit;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 32; k++) begin m_cnt[k] = 0; m_typ[k] = 0; end
      m_ovf = 0; m_rd = 0;
    end else begin
      rdv = 0;
      if (reg_sel) begin if (reg_idx < NE) rdv = {48'd0, m_typ[reg_idx]}; end
      else if (reg_idx < NE || reg_idx == 31) rdv = m_cnt[reg_idx];
      chain_prev = 0;
      for (int k = 0; k < NE; k++) begin
        nxt_chain = 0;
        hit = glb_en && cnt_en[k] &&
              ((evt_valid && m_typ[k] == evt_code && m_typ[k] != 16'h0 && m_typ[k] != 16'h1E) ||
               (sw_we && sw_mask[k] && m_typ[k] == 16'h0) ||
               (chain_prev && m_typ[k] == 16'h1E));
        if (reg_we && !reg_sel && reg_idx == k)
          m_cnt[k] = acc32 ? {m_cnt[k][63:32], reg_wdata[31:0]} : reg_wdata;
        else if (hit) begin
          m_cnt[k] = m_cnt[k] + 1;
          if (long_evt ? (m_cnt[k] == 0) : (m_cnt[k][31:0] == 0)) begin
            m_ovf[k] = 1'b1;
            if (!long_evt && k % 2 == 0 && k + 1 < NE) nxt_chain = 1;
          end
        end
        chain_prev = nxt_chain;
      end
      if (reg_we && !reg_sel && reg_idx == 31) m_cnt[31] = reg_wdata;
      else if (glb_en && cnt_en[31]) begin
        m_cnt[31] = m_cnt[31] + 1;
        if (long_cyc ? (m_cnt[31] == 0) : (m_cnt[31][31:0] == 0)) m_ovf[31] = 1'b1;
      end
      if (reg_we && reg_sel && reg_idx < NE) m_typ[reg_idx] = reg_wdata[15:0];
      m_rd = rdv;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(reg_rdata == m_rd, "R1 model rdata", reg_rdata, m_rd);
      check(ovf_status == m_ovf, "R4 model ovf_status", {32'd0, ovf_status}, {32'd0, m_ovf});
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input bit sel, input int idx, input logic [63:0] d);
    reg_we = 1; reg_sel = sel; reg_idx = idx[4:0]; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd_chk(input bit sel, input int idx, input logic [63:0] exp, input string tag);
    reg_sel = sel; reg_idx = idx[4:0];
    tick();
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic ovf_chk(input int bitn, input bit exp, input string tag);
    check(ovf_status[bitn] == exp, tag, {63'd0, ovf_status[bitn]}, {63'd0, exp});
  endtask

  task automatic fire(input logic [15:0] code, input int n);
    evt_valid = 1; evt_code = code;
    repeat (n) tick();
    evt_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [63:0] NEAR [6] = '{64'hFFFF_FFFE, 64'hFFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h1_FFFF_FFFF, 64'h0, 64'h5};

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    rd_chk(0, 0, 0, "R1 reset counter");
    check(ovf_status == 0, "R1 reset status", {32'd0, ovf_status}, 0);

    wr(1, 0, 64'h11); wr(1, 1, 64'h1E); wr(1, 2, 64'h0);
    wr(1, 3, 64'h1_ABCD); wr(1, 4, 64'h22); wr(1, 5, 64'h1E);
    rd_chk(1, 3, 64'hABCD, "R2 type keeps low 16 bits");
    rd_chk(1, 31, 0, "R1 cycle type reads zero");
    wr(0, 20, 64'h5);
    rd_chk(0, 20, 0, "R1 absent index ignored");

    cnt_en = 32'h7FFF_FFFF;
    fire(16'h11, 3);
    rd_chk(0, 0, 0, "R2 global disable");
    glb_en = 1;
    fire(16'h11, 3);
    rd_chk(0, 0, 3, "R2 counts matching event");
    fire(16'h12, 2);
    cnt_en[0] = 0; fire(16'h11, 2); cnt_en[0] = 1;
    rd_chk(0, 0, 3, "R2 other code or own enable off");
    fire(16'h0, 2);
    rd_chk(0, 2, 0, "R2 sw-typed ignores event bus");

    wr(0, 0, 64'hFFFF_FFFE);
    fire(16'h11, 2);
    rd_chk(0, 0, 64'h1_0000_0000, "R3 64-bit event counter");
    rd_chk(0, 1, 1, "R6 chain step on overflow");
    ovf_chk(0, 1, "R4 low-32 wrap sets status");

    long_evt = 1;
    wr(0, 4, 64'hFFFF_FFFF);
    fire(16'h22, 1);
    rd_chk(0, 4, 64'h1_0000_0000, "R4 long mode value");
    ovf_chk(4, 0, "R4 long mode ignores 32 wrap");
    wr(0, 4, 64'hFFFF_FFFF_FFFF_FFFF);
    fire(16'h22, 1);
    rd_chk(0, 4, 0, "R4 64-bit wrap value");
    ovf_chk(4, 1, "R4 64-bit wrap sets status");
    rd_chk(0, 5, 0, "R7 no chain in long mode");
    long_evt = 0;

    sw_we = 1; sw_mask = 31'b1100; tick(); sw_we = 0;
    rd_chk(0, 2, 1, "R8 sw increment");
    rd_chk(0, 3, 0, "R8 non-sw type untouched");
    cnt_en[2] = 0; sw_we = 1; tick(); sw_we = 0; cnt_en[2] = 1;
    rd_chk(0, 2, 1, "R8 disabled counter untouched");
    wr(1, 0, 64'h0); wr(0, 0, 64'hFFFF_FFFF);
    sw_we = 1; sw_mask = 31'b1; tick(); sw_we = 0;
    rd_chk(0, 1, 2, "R8 sw overflow chains");

    wr(0, 2, 64'hAAAA_BBBB_CCCC_DDDD);
    acc32 = 1;
    wr(0, 2, 64'h1111_2222_3333_4444);
    wr(0, 31, 64'h1111_2222_3333_4444);
    acc32 = 0;
    rd_chk(0, 2, 64'hAAAA_BBBB_3333_4444, "R9 upper half kept");
    rd_chk(0, 31, 64'h1111_2222_3333_4444, "R9 cycle counter full write");

    wr(1, 0, 64'h11);
    evt_valid = 1; evt_code = 16'h11;
    wr(0, 0, 64'h50);
    evt_valid = 0;
    rd_chk(0, 0, 64'h50, "R10 write beats step");

    long_cyc = 1;
    wr(0, 31, 64'h1_FFFF_FFFF);
    cnt_en[31] = 1; tick(); cnt_en[31] = 0;
    rd_chk(0, 31, 64'h2_0000_0000, "R5 long cycle value");
    ovf_chk(31, 0, "R5 long cycle ignores 32 wrap");
    wr(0, 31, 64'hFFFF_FFFF_FFFF_FFFF);
    cnt_en[31] = 1; tick(); cnt_en[31] = 0;
    ovf_chk(31, 1, "R5 64-bit cycle wrap");
    long_cyc = 0;
    rst = 1; tick(); rst = 0; tick();
    wr(0, 31, 64'hFFFF_FFFE);
    cnt_en[31] = 1; tick(); tick(); cnt_en[31] = 0;
    rd_chk(0, 31, 64'h1_0000_0000, "R5 cycle counts");
    ovf_chk(31, 1, "R5 low-32 cycle wrap");

    for (int c = 0; c < 400; c++) begin
      glb_en    = ($urandom_range(0, 7) != 0);
      long_evt  = ($urandom_range(0, 3) == 0);
      long_cyc  = $urandom_range(0, 1);
      acc32     = $urandom_range(0, 1);
      cnt_en    = $urandom;
      evt_valid = $urandom_range(0, 1);
      evt_code  = ($urandom_range(0, 1) != 0) ? 16'h11 : 16'h22;
      sw_we     = $urandom_range(0, 1);
      sw_mask   = 31'($urandom);
      reg_we    = ($urandom_range(0, 3) == 0);
      reg_sel   = ($urandom_range(0, 2) == 0);
      reg_idx   = ($urandom_range(0, 7) == 0) ? 5'd31 : 5'($urandom_range(0, NE));
      case ($urandom_range(0, 3))
        0: reg_wdata = 64'h0;
        1: reg_wdata = 64'h1E;
        2: reg_wdata = 64'h11;
        default: reg_wdata = 64'h22;
      endcase
      if (!reg_sel) reg_wdata = NEAR[$urandom_range(0, 5)];
      tick();
    end
    reg_we = 0; evt_valid = 0; sw_we = 0;
    tick();
    finish_run();
  end
endmodule